// File: doc/BRIEF.md
# Cascadable Serial-Load Latched Switch Driver

This block models the digital side of a latched low-side switch driver. A serial bit stream is clocked into an 8-stage shift register on one clock. A separate storage clock copies the whole register into a holding register in one step. The holding register drives eight switch-enable outputs through a combinational gate, where a 1 means that output's sink transistor conducts. An active-low enable forces every output off. An active-low clear empties all of the state asynchronously.

The last shift stage is brought out as a cascade output that changes on the falling edge of the shift clock. Because of this, several devices can be chained, feeding each cascade output to the next device's serial input. The chain still shifts correctly when each device sees the shift clock a little later than the one before it. To update a chain of N devices, shift in N×8 bits, then pulse the shared storage clock once.

Top module: `serial_latch_driver`

## Requirements
- R1: On every rising edge of `shift_clk`, stage 0 of the shift register takes `ser_in` and every stage i moves to stage i+1.
- R2: On every rising edge of `store_clk`, the holding register takes a copy of all eight shift stages.
- R3: While `clear_n` is low, the shift register, the holding register and `cascade_out` are all zero, with no clock edge needed.
- R4: While `out_en_n` is high, all bits of `sink_on` are 0 at once, whatever the holding register contains.
- R5: While `out_en_n` is low, `sink_on[i]` equals holding bit i (1 = sink on, 0 = off), and follows an enable change without any clock edge.
- R6: `cascade_out` takes the value of stage 7 on the falling edge of `shift_clk` and keeps its value across the rising edge.
- R7: After at least eight shifts since a clear, `cascade_out` shows the `ser_in` bit taken in eight rising shift edges earlier.
- R8: In a chain of devices, shifting in N×8 bits and then pulsing `store_clk` once updates all devices together. The first bit shifted ends up in stage 7 of the last device.
- R9: The chain shifts without error when each downstream device's `shift_clk` lags the upstream one by less than half a clock period.
- R10: Shift edges alone leave `sink_on` unchanged until the next `store_clk` edge.
- R11: When the rising edges of `store_clk` and `shift_clk` coincide, the holding register captures the shift contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; shifts on the rising edge, updates the cascade output on the falling edge |
| store_clk | input | 1 | Storage clock; copies the shift register on the rising edge |
| clear_n | input | 1 | Asynchronous active-low clear of all registers |
| out_en_n | input | 1 | Active-low output enable |
| ser_in | input | 1 | Serial data input |
| sink_on | output | 8 | Switch enables, 1 = sink transistor on |
| cascade_out | output | 1 | Serial cascade output to the next device |

## Verification
Two functions can fall in the same cycle: a shift and a storage update. The bench drives rising edges of the storage clock and of the first device's shift clock in the same time step, and in some of these cycles it drives the skewed downstream clocks as well. The storage clock is shared across the three-device chain. The reference model takes its snapshot before it applies the shift. The bench then checks that every device holds the snapshot from before the shift and not the one after.

// File: rtl/sld_pkg.sv
package sld_pkg;

  // Which shift-clock edge drives the cascade flop
  typedef enum logic {
    CASC_FALL = 1'b0,
    CASC_RISE = 1'b1
  } casc_edge_e;

  // One output lane: a stored 1 turns the sink on unless the enable is released
  function automatic logic lane_drive(input logic held, input logic en_n);
    return held & ~en_n;
  endfunction

  // Next value of one shift stage: stage 0 takes serial data, others the lower stage
  function automatic logic stage_next(input int unsigned idx, input logic ser,
                                      input logic lower);
    return (idx == 0) ? ser : lower;
  endfunction

endpackage

// File: rtl/sld_shift_chain.sv
module sld_shift_chain
  import sld_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter casc_edge_e  CASC_EDGE = CASC_FALL
) (
  input  logic             shift_clk,
  input  logic             clear_n,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stages,
  output logic             cascade
);

  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;
  logic             casc_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stage_d[i] = stage_next(i, ser_in, 1'b0);
    end else begin : g_body
      assign stage_d[i] = stage_next(i, ser_in, stage_q[i-1]);
    end
  end

  always_ff @(posedge shift_clk or negedge clear_n) begin
    if (!clear_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  if (CASC_EDGE == CASC_FALL) begin : g_casc_fall
    always_ff @(negedge shift_clk or negedge clear_n) begin
      if (!clear_n) begin
        casc_q <= 1'b0;
      end else begin
        casc_q <= stage_q[LAST];
      end
    end
  end else begin : g_casc_rise
    always_ff @(posedge shift_clk or negedge clear_n) begin
      if (!clear_n) begin
        casc_q <= 1'b0;
      end else begin
        casc_q <= stage_q[LAST];
      end
    end
  end

  assign stages  = stage_q;
  assign cascade = casc_q;

endmodule

// File: rtl/sld_store_reg.sv
module sld_store_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             store_clk,
  input  logic             clear_n,
  input  logic [WIDTH-1:0] snap_in,
  output logic [WIDTH-1:0] held
);

  logic [WIDTH-1:0] held_q;

  always_ff @(posedge store_clk or negedge clear_n) begin
    if (!clear_n) begin
      held_q <= '0;
    end else begin
      held_q <= snap_in;
    end
  end

  assign held = held_q;

endmodule

// File: rtl/sld_out_gate.sv
module sld_out_gate
  import sld_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] held,
  input  logic             out_en_n,
  output logic [WIDTH-1:0] sink_on
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign sink_on[i] = lane_drive(held[i], out_en_n);
  end

endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
  import sld_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter casc_edge_e  CASC_EDGE = CASC_FALL
) (
  input  logic             shift_clk,
  input  logic             store_clk,
  input  logic             clear_n,
  input  logic             out_en_n,
  input  logic             ser_in,
  output logic [WIDTH-1:0] sink_on,
  output logic             cascade_out
);

  // Named internal state, visible to the bound checker
  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] store_q;

  sld_shift_chain #(
    .WIDTH     (WIDTH),
    .CASC_EDGE (CASC_EDGE)
  ) u_shift (
    .shift_clk (shift_clk),
    .clear_n   (clear_n),
    .ser_in    (ser_in),
    .stages    (shift_q),
    .cascade   (cascade_out)
  );

  sld_store_reg #(
    .WIDTH (WIDTH)
  ) u_store (
    .store_clk (store_clk),
    .clear_n   (clear_n),
    .snap_in   (shift_q),
    .held      (store_q)
  );

  sld_out_gate #(
    .WIDTH (WIDTH)
  ) u_gate (
    .held     (store_q),
    .out_en_n (out_en_n),
    .sink_on  (sink_on)
  );

endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             shift_clk,
  input logic             store_clk,
  input logic             clear_n,
  input logic             out_en_n,
  input logic             ser_in,
  input logic [WIDTH-1:0] sink_on,
  input logic             cascade_out,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] store_q
);

  // A previous edge was taken with clear released and no clear since
  logic             sh_live_q;
  logic             st_live_q;
  logic             prev_ser_q;
  logic [WIDTH-1:0] prev_snap_q;

  always_ff @(posedge shift_clk or negedge clear_n) begin
    if (!clear_n) begin
      sh_live_q  <= 1'b0;
      prev_ser_q <= 1'b0;
    end else begin
      sh_live_q  <= 1'b1;
      prev_ser_q <= ser_in;
    end
  end

  always_ff @(posedge store_clk or negedge clear_n) begin
    if (!clear_n) begin
      st_live_q   <= 1'b0;
      prev_snap_q <= '0;
    end else begin
      st_live_q   <= 1'b1;
      prev_snap_q <= shift_q;
    end
  end

  // R1: stage 0 holds the serial bit seen at the previous rising edge
  a_r1_stage0_takes_ser: assert property (@(posedge shift_clk) disable iff (!clear_n)
    sh_live_q |-> (shift_q[0] == prev_ser_q));

  // R2: holding register equals the snapshot seen at the previous storage edge
  a_r2_store_copies: assert property (@(posedge store_clk) disable iff (!clear_n)
    st_live_q |-> (store_q == prev_snap_q));

  // R3: clear empties every register
  a_r3_clear_empties: assert property (@(posedge shift_clk)
    !clear_n |-> (shift_q == '0 && store_q == '0 && cascade_out == 1'b0));

  // R4: released enable forces all sinks off
  a_r4_disable_forces_off: assert property (@(posedge shift_clk) disable iff (!clear_n)
    out_en_n |-> (sink_on == '0));

  // R5: asserted enable shows the holding register
  a_r5_enable_passes: assert property (@(posedge store_clk) disable iff (!clear_n)
    !out_en_n |-> (sink_on == store_q));

  // R6: the cascade took the top stage at the falling edge after the last rise
  a_r6_cascade_fall: assert property (@(posedge shift_clk) disable iff (!clear_n)
    sh_live_q |-> (cascade_out == shift_q[WIDTH-1]));

endmodule

bind serial_latch_driver sld_checker #(.WIDTH(WIDTH)) u_chk (
  .shift_clk   (shift_clk),
  .store_clk   (store_clk),
  .clear_n     (clear_n),
  .out_en_n    (out_en_n),
  .ser_in      (ser_in),
  .sink_on     (sink_on),
  .cascade_out (cascade_out),
  .shift_q     (shift_q),
  .store_q     (store_q)
);

// File: tb/serial_latch_driver_tb.sv
module serial_latch_driver_tb;

  localparam int W    = 8;
  localparam int DEVS = 3;
  localparam int TOT  = W * DEVS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic sclk0 = 1'b0, sclk1 = 1'b0, sclk2 = 1'b0;
  logic rclk = 1'b0, clear_n = 1'b1, oen = 1'b0, ser = 1'b0;
  logic [W-1:0] sink0, sink1, sink2;
  logic casc0, casc1, casc2;

  // Skewed shift clocks for downstream devices (R9)
  always @(sclk0) begin #1; sclk1 = sclk0; end
  always @(sclk1) begin #1; sclk2 = sclk1; end

  serial_latch_driver u_dut (
    .shift_clk(sclk0), .store_clk(rclk), .clear_n(clear_n), .out_en_n(oen),
    .ser_in(ser), .sink_on(sink0), .cascade_out(casc0));
  serial_latch_driver u_dut_s1 (
    .shift_clk(sclk1), .store_clk(rclk), .clear_n(clear_n), .out_en_n(oen),
    .ser_in(casc0), .sink_on(sink1), .cascade_out(casc1));
  serial_latch_driver u_dut_s2 (
    .shift_clk(sclk2), .store_clk(rclk), .clear_n(clear_n), .out_en_n(oen),
    .ser_in(casc1), .sink_on(sink2), .cascade_out(casc2));

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [TOT-1:0] m_sr = '0;   // device d owns bits [d*8 +: 8], bit 0 of device 0 first
  logic [TOT-1:0] m_st = '0;
  logic hist [0:4095];
  int   nsh = 0;

  function automatic logic [W-1:0] exp_sink(input int d);
    return oen ? '0 : m_st[d*W +: W];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic check_sinks(input string req);
    check(sink0 == exp_sink(0), req, {24'd0, sink0}, {24'd0, exp_sink(0)});
    check(sink1 == exp_sink(1), req, {24'd0, sink1}, {24'd0, exp_sink(1)});
    check(sink2 == exp_sink(2), req, {24'd0, sink2}, {24'd0, exp_sink(2)});
  endtask

  task automatic do_shift(input logic b, input bit with_store);
    logic pre;
    @(negedge clk);
    ser = b;
    pre = casc0;
    @(posedge clk);
    sclk0 = 1'b1;
    if (with_store) begin
      rclk = 1'b1;
      m_st = m_sr;                 // R11: snapshot before the shift
    end
    m_sr = {m_sr[TOT-2:0], b};
    hist[nsh] = b;
    nsh++;
    #2;
    check(casc0 == pre, "R6 cascade held across rise", {31'd0, casc0}, {31'd0, pre});
    @(negedge clk);
    sclk0 = 1'b0;
    rclk  = 1'b0;
    #4;
    check(casc2 == m_sr[TOT-1], "R6/R9 last cascade", {31'd0, casc2}, {31'd0, m_sr[TOT-1]});
    if (nsh >= W)
      check(casc0 == hist[nsh-W], "R7 eight-edge delay", {31'd0, casc0},
            {31'd0, hist[nsh-W]});
    check_sinks(with_store ? "R11 coincident edges" : "R10 no store no change");
  endtask

  task automatic do_store();
    @(posedge clk);
    rclk = 1'b1;
    m_st = m_sr;
    @(negedge clk);
    rclk = 1'b0;
    #1;
    check_sinks("R2/R8 store all devices");
  endtask

  task automatic load_chain(input logic [TOT-1:0] pat);
    // bit TOT-1 goes first so it ends in the last device's top stage
    for (int i = TOT - 1; i >= 0; i--) do_shift(pat[i], 1'b0);
    check(m_sr == pat, "R8 model order", m_sr, pat);
  endtask

  task automatic do_clear();
    @(negedge clk);
    #1 clear_n = 1'b0;
    #1;
    m_sr = '0;
    m_st = '0;
    nsh  = 0;
    check(sink0 == 0 && sink1 == 0 && sink2 == 0, "R3 sinks cleared",
          {8'd0, sink2, sink1, sink0}, 32'd0);
    check({casc0, casc1, casc2} == 3'b000, "R3 cascades cleared",
          {29'd0, casc0, casc1, casc2}, 32'd0);
    #2 clear_n = 1'b1;
  endtask

  initial begin
    logic [TOT-1:0] pat;
    void'($urandom(32'd20240611));
    #1 clear_n = 1'b0;
    #2;
    check(sink0 == 0 && sink1 == 0 && sink2 == 0, "R3 reset sinks",
          {8'd0, sink2, sink1, sink0}, 32'd0);
    check({casc0, casc1, casc2} == 3'b000, "R3 reset cascades",
          {29'd0, casc0, casc1, casc2}, 32'd0);
    #4 clear_n = 1'b1;

    // Directed: single marker bit walks to the last device's top stage (R1, R8)
    load_chain(24'h800000);
    do_store();
    check(sink2 == 8'h80, "R1/R8 marker in last device", {24'd0, sink2}, 32'h80);
    check(sink0 == 8'h00, "R5 first device off", {24'd0, sink0}, 32'h0);

    load_chain(24'hFFFFFF);
    do_store();
    load_chain(24'h5AA5C3);
    do_store();

    // R4 / R5: enable gating without clocks
    #1 oen = 1'b1;
    #1;
    check({sink2, sink1, sink0} == 24'd0, "R4 disabled all off",
          {8'd0, sink2, sink1, sink0}, 32'd0);
    #1 oen = 1'b0;
    #1;
    check({sink2, sink1, sink0} == 24'h5AA5C3, "R5 re-enabled passes",
          {8'd0, sink2, sink1, sink0}, 32'h5AA5C3);

    // Random chains with occasional coincident store
    for (int r = 0; r < 12; r++) begin
      pat = {$urandom(), $urandom()};
      for (int i = TOT - 1; i >= 0; i--) do_shift(pat[i], ($urandom() % 9) == 0);
      if (r % 4 == 3) begin
        oen = 1'b1;
        do_store();
        oen = 1'b0;
        #1 check_sinks("R5 enable after store");
      end else begin
        do_store();
      end
    end

    // Mid-run asynchronous clear, then reload (R3)
    do_clear();
    do_store();
    check({sink2, sink1, sink0} == 24'd0, "R3 storage stays empty",
          {8'd0, sink2, sink1, sink0}, 32'd0);
    for (int i = 0; i < 30; i++) do_shift($urandom() % 2 == 1, 1'b0);
    do_store();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule